// File: doc/BRIEF.md
# Rate-Gyro SPI Command Frame Engine

This block sits between a simple request port and the four-wire SPI link of a rate-gyro sensor. A client asks for one of three operations: fetch the angular-rate sample, read a 16-bit register pair, or write a 16-bit register pair. Each request carries an 8-bit register address and 16 bits of write data. The engine builds the 32-bit command word and adds its parity bit. It shifts the word out most significant bit first in SPI mode 0. It clocks in the reply and pulls the result, the two status bits and the write-error bits out of it.

Reads and rate fetches take two chip-select frames. The command goes out in the first frame, and the reply arrives in a second frame whose outgoing bits are all zero. A write takes one frame, and its reply comes back during that same frame. Chip select stays high for a minimum number of clocks between any two frames. After a write, the idle time is stretched to at least 100 microseconds, computed from the clock-rate parameter. Requests are taken only while the engine is idle. The results come with a single-cycle done pulse.

Top module: `gyro_frame_engine`

## Requirements
- R1: Frames are 32 bits, shifted most significant bit first in SPI mode 0. The serial clock is low whenever chip select is high. The outgoing bit changes only on a falling serial clock edge. The incoming bit is captured on each rising edge, and there are exactly 32 rising edges per frame.
- R2: Request kind code 0 is a rate fetch, code 1 is a register read and code 2 is a register write. The command word sets bit 29 for a rate fetch, bit 31 for a read and bit 30 for a write. Reads and writes place the address in bits 24:17. Writes place the data in bits 16:1. A rate fetch sends no address, and every unused bit is zero.
- R3: Bit 0 of every command word is a parity bit chosen so that the 32-bit word holds an odd number of ones.
- R4: A register read uses two frames with chip select released between them. The second frame sends all zeros, and the result is bits 20:5 of the second reply.
- R5: A rate fetch uses the same two-frame pattern, and the result is bits 25:10 of the second reply.
- R6: The status output is bits 27:26 of the final reply. The write-error output is bits 31:29 of the reply on a write and zero for the other kinds.
- R7: A write uses a single frame and its result is bits 20:5 of that frame's reply. The next chip-select fall comes no sooner than the number of clocks in 100 microseconds after the write frame ends.
- R8: Chip select stays high for at least CS_GAP_CLKS clocks between any two frames.
- R9: The ready output is high only while idle, and the reset state is idle. A request valid while busy starts no frame and changes no command.
- R10: The done output is a single-cycle pulse in the cycle after the final incoming bit is captured, so the serial clock is still high and chip select still low in that cycle.
- R11: While in reset, chip select is high, the serial clock is low, ready is high and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle; a request is taken |
| req_kind | input | 2 | 0 rate fetch, 1 register read, 2 register write |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Register write data |
| done | output | 1 | One-cycle completion pulse |
| rd_result | output | 16 | Rate sample or register value |
| rd_status | output | 2 | Status field of the final reply |
| wr_error | output | 3 | Write-error bits (writes only) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to sensor |
| spi_miso | input | 1 | Serial data from sensor |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The table mixes all three request kinds. It uses addresses and data of all zeros, all ones and mixed patterns, so the command encoding and the parity bit are tried both when parity must be set and when it must stay clear. Each reply is filled with a different background pattern around the fields, including all ones, alternating bits and all zeros. This shows whether the result comes from the right window of the right frame: a rate window or a register window, and the second frame rather than the first for reads. It also shows whether the write-error bits are masked off outside writes. Directed cases hold a request valid while a read is in flight to show that it is ignored. A request issued straight after a write measures the stretched idle gap.

// File: rtl/gyro_pkg.sv
package gyro_pkg;
    localparam int FRAME_W  = 32;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int STAT_W   = 2;
    localparam int WERR_W   = 3;
    localparam int BITCNT_W = $clog2(FRAME_W);

    // command word bit positions
    localparam int CMD_RD_BIT   = 31;
    localparam int CMD_WR_BIT   = 30;
    localparam int CMD_RATE_BIT = 29;
    localparam int ADDR_LSB     = 17;
    localparam int WDATA_LSB    = 1;

    // reply word field positions
    localparam int WERR_LSB     = 29;
    localparam int STAT_LSB     = 26;
    localparam int RATE_LSB     = 10;
    localparam int REGVAL_LSB   = 5;

    typedef enum logic [1:0] {
        KIND_RATE = 2'd0,
        KIND_RD   = 2'd1,
        KIND_WR   = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2,
        S_GAP  = 2'd3
    } seq_e;
endpackage

// File: rtl/gyro_cmd_encode.sv
module gyro_cmd_encode
    import gyro_pkg::*;
(
    input  req_kind_e          kind,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [FRAME_W-1:0] cmd
);
    logic [FRAME_W-1:0] body;

    always_comb begin
        body = '0;
        case (kind)
            KIND_RD: begin
                body[CMD_RD_BIT] = 1'b1;
                body[ADDR_LSB +: ADDR_W] = addr;
            end
            KIND_WR: begin
                body[CMD_WR_BIT] = 1'b1;
                body[ADDR_LSB +: ADDR_W] = addr;
                body[WDATA_LSB +: DATA_W] = wdata;
            end
            default: body[CMD_RATE_BIT] = 1'b1;
        endcase
        // bit 0 makes the total count of ones odd
        cmd = {body[FRAME_W-1:1], ~(^body[FRAME_W-1:1])};
    end
endmodule

// File: rtl/gyro_resp_decode.sv
module gyro_resp_decode
    import gyro_pkg::*;
(
    input  req_kind_e          kind,
    input  logic [FRAME_W-1:0] word,
    output logic [DATA_W-1:0]  result,
    output logic [STAT_W-1:0]  status,
    output logic [WERR_W-1:0]  werr
);
    logic unused_bits;
    assign unused_bits = ^{word[28], word[4:0]};

    always_comb begin
        result = (kind == KIND_RATE) ? word[RATE_LSB +: DATA_W]
                                     : word[REGVAL_LSB +: DATA_W];
        status = word[STAT_LSB +: STAT_W];
        werr   = (kind == KIND_WR) ? word[WERR_LSB +: WERR_W] : '0;
    end
endmodule

// File: rtl/gyro_frame_engine.sv
module gyro_frame_engine
    import gyro_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 125_000_000,
    parameter int SCLK_HALF   = 4,
    parameter int CS_GAP_CLKS = 8,
    parameter int WR_GAP_US   = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_kind,
    input  logic [7:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        done,
    output logic [15:0] rd_result,
    output logic [1:0]  rd_status,
    output logic [2:0]  wr_error,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n
);
    localparam int WR_GAP_RAW  = (CLK_FREQ_HZ / 1000) * WR_GAP_US / 1000;
    localparam int WR_GAP_CLKS = (WR_GAP_RAW > CS_GAP_CLKS) ? WR_GAP_RAW : CS_GAP_CLKS;
    localparam int TMR_MAX     = (WR_GAP_CLKS > SCLK_HALF) ? WR_GAP_CLKS : SCLK_HALF;
    localparam int TMR_W       = $clog2(TMR_MAX + 1);

    typedef struct packed {
        seq_e                seq;
        logic [TMR_W-1:0]    tmr;
        logic [BITCNT_W-1:0] nbit;
        logic                sclk;
        logic                cs_n;
        logic [FRAME_W-1:0]  tx;
        logic [FRAME_W-1:0]  rx;
        req_kind_e           kind;
        logic                second_pending;
        logic                done;
        logic [DATA_W-1:0]   result;
        logic [STAT_W-1:0]   status;
        logic [WERR_W-1:0]   werr;
    } state_t;

    state_t st_q, st_d;

    req_kind_e          kind_in;
    logic [FRAME_W-1:0] cmd_w;
    logic [FRAME_W-1:0] rx_next;
    logic [DATA_W-1:0]  dec_result;
    logic [STAT_W-1:0]  dec_status;
    logic [WERR_W-1:0]  dec_werr;
    logic [TMR_W-1:0]   gap_last;
    logic               unused_rx_top;

    assign kind_in       = req_kind_e'(req_kind);
    assign rx_next       = {st_q.rx[FRAME_W-2:0], spi_miso};
    assign unused_rx_top = st_q.rx[FRAME_W-1];
    assign gap_last      = (st_q.kind == KIND_WR) ? TMR_W'(WR_GAP_CLKS - 1)
                                                  : TMR_W'(CS_GAP_CLKS - 1);

    gyro_cmd_encode enc_i (
        .kind  (kind_in),
        .addr  (req_addr),
        .wdata (req_wdata),
        .cmd   (cmd_w)
    );

    gyro_resp_decode dec_i (
        .kind   (st_q.kind),
        .word   (rx_next),
        .result (dec_result),
        .status (dec_status),
        .werr   (dec_werr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.seq)
            S_IDLE: begin
                if (req_valid) begin
                    st_d.kind           = kind_in;
                    st_d.tx             = cmd_w;
                    st_d.cs_n           = 1'b0;
                    st_d.sclk           = 1'b0;
                    st_d.tmr            = '0;
                    st_d.nbit           = '0;
                    st_d.second_pending = (kind_in != KIND_WR);
                    st_d.seq            = S_LOW;
                end
            end
            S_LOW: begin
                if (st_q.tmr == TMR_W'(SCLK_HALF - 1)) begin
                    st_d.tmr  = '0;
                    st_d.sclk = 1'b1;
                    st_d.rx   = rx_next;
                    st_d.seq  = S_HIGH;
                    if (st_q.nbit == BITCNT_W'(FRAME_W - 1) && !st_q.second_pending) begin
                        st_d.done   = 1'b1;
                        st_d.result = dec_result;
                        st_d.status = dec_status;
                        st_d.werr   = dec_werr;
                    end
                end else begin
                    st_d.tmr = st_q.tmr + TMR_W'(1);
                end
            end
            S_HIGH: begin
                if (st_q.tmr == TMR_W'(SCLK_HALF - 1)) begin
                    st_d.tmr  = '0;
                    st_d.sclk = 1'b0;
                    if (st_q.nbit == BITCNT_W'(FRAME_W - 1)) begin
                        st_d.cs_n = 1'b1;
                        st_d.seq  = S_GAP;
                    end else begin
                        st_d.nbit = st_q.nbit + BITCNT_W'(1);
                        st_d.tx   = {st_q.tx[FRAME_W-2:0], 1'b0};
                        st_d.seq  = S_LOW;
                    end
                end else begin
                    st_d.tmr = st_q.tmr + TMR_W'(1);
                end
            end
            default: begin // S_GAP
                if (st_q.tmr == gap_last) begin
                    st_d.tmr = '0;
                    if (st_q.second_pending) begin
                        st_d.second_pending = 1'b0;
                        st_d.cs_n           = 1'b0;
                        st_d.tx             = '0;
                        st_d.nbit           = '0;
                        st_d.seq            = S_LOW;
                    end else begin
                        st_d.seq = S_IDLE;
                    end
                end else begin
                    st_d.tmr = st_q.tmr + TMR_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.seq == S_IDLE);
    assign done      = st_q.done;
    assign rd_result = st_q.result;
    assign rd_status = st_q.status;
    assign wr_error  = st_q.werr;
    assign spi_sclk  = st_q.sclk;
    assign spi_mosi  = st_q.tx[FRAME_W-1];
    assign spi_cs_n  = st_q.cs_n;
endmodule

// File: rtl/gyro_frame_engine_chk.sv
module gyro_frame_engine_chk #(
    parameter int CS_GAP_CLKS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n
);
    localparam int HI_W   = $clog2(CS_GAP_CLKS + 2) + 1;
    localparam int HI_SAT = (1 << HI_W) - 1;

    logic [HI_W-1:0] hi_cnt;

    // counts consecutive cycles with chip select high, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= HI_W'(HI_SAT);
        else if (!spi_cs_n)
            hi_cnt <= '0;
        else if (hi_cnt != HI_W'(HI_SAT))
            hi_cnt <= hi_cnt + HI_W'(1);
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R1

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R1

    AST_CS_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (int'(hi_cnt) >= CS_GAP_CLKS)); // R8

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (spi_cs_n && !spi_sclk)); // R9

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!spi_cs_n && !req_ready)); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_IN_LAST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_sclk && !spi_cs_n)); // R10
endmodule

bind gyro_frame_engine gyro_frame_engine_chk #(.CS_GAP_CLKS(CS_GAP_CLKS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n)
);

// File: tb/gyro_frame_engine_tb_top.sv
`timescale 1ns/1ps
module gyro_frame_engine_tb_top;
    localparam int CLK_HZ = 2_000_000;
    localparam int HALF   = 2;
    localparam int CSG    = 6;
    localparam int WRG    = 200; // 100 us at 2 MHz

    // {kind[2], addr[8], wdata[16], status[2], value[16], werr[3], background[32]}
    localparam logic [78:0] VEC [0:7] = '{
        {2'd0, 8'h00, 16'h0000, 2'd2, 16'h8001, 3'd0, 32'hFFFF_FFFF},
        {2'd0, 8'h3C, 16'hFFFF, 2'd1, 16'h7FFF, 3'd0, 32'h0000_0000},
        {2'd1, 8'h0A, 16'h0000, 2'd2, 16'h0FFF, 3'd0, 32'hAAAA_AAAA},
        {2'd2, 8'h12, 16'h03FF, 2'd3, 16'h0000, 3'd5, 32'hF0F0_F0F0},
        {2'd1, 8'h0E, 16'h0000, 2'd0, 16'h1234, 3'd0, 32'h5555_5555},
        {2'd2, 8'hFF, 16'hFFFF, 2'd1, 16'hABCD, 3'd0, 32'h0000_0000},
        {2'd1, 8'h00, 16'h0000, 2'd3, 16'hFFFF, 3'd0, 32'hFFFF_FFFF},
        {2'd2, 8'h00, 16'h0000, 2'd0, 16'h0000, 3'd7, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [7:0]  req_addr = 8'h00;
    logic [15:0] req_wdata = 16'h0000;
    logic        done;
    logic [15:0] rd_result;
    logic [1:0]  rd_status;
    logic [2:0]  wr_error;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    gyro_frame_engine #(
        .CLK_FREQ_HZ (CLK_HZ),
        .SCLK_HALF   (HALF),
        .CS_GAP_CLKS (CSG),
        .WR_GAP_US   (100)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rd_result(rd_result), .rd_status(rd_status), .wr_error(wr_error),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    // sensor model: per-frame reply, capture of outgoing bits, edge and gap counts
    logic [31:0] replies [0:3];
    logic [31:0] frames  [0:3];
    int          rises   [0:3];
    int          gaps    [0:3];
    int          fidx = 0;
    logic [31:0] shreg = '0;
    logic [31:0] cap = '0;
    int          rc = 0;
    int          hi = 0;

    always @(negedge spi_cs_n) begin
        shreg = (fidx < 4) ? replies[fidx] : 32'h0;
        spi_miso = shreg[31];
        cap = '0;
        rc = 0;
    end
    always @(posedge spi_sclk) if (!spi_cs_n) begin
        cap = {cap[30:0], spi_mosi};
        rc++;
    end
    always @(negedge spi_sclk) if (!spi_cs_n) begin
        shreg = {shreg[30:0], 1'b0};
        spi_miso = shreg[31];
    end
    always @(posedge spi_cs_n) if (rst_n) begin
        if (fidx < 4) begin
            frames[fidx] = cap;
            rises[fidx] = rc;
        end
        fidx++;
    end
    always @(negedge clk) begin
        if (spi_cs_n === 1'b1) hi++;
        else if (hi != 0) begin
            if (fidx < 4) gaps[fidx] = hi;
            hi = 0;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_ge(input string tag, input string what, input int act, input int lim);
        nchk++;
        if (act < lim) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected>=%0d", tag, what, act, lim);
        end
    endtask

    function automatic logic [31:0] exp_cmd(input logic [1:0] k, input logic [7:0] a,
                                            input logic [15:0] d);
        logic [31:0] w = '0;
        if (k == 2'd1) begin w[31] = 1'b1; w[24:17] = a; end
        else if (k == 2'd2) begin w[30] = 1'b1; w[24:17] = a; w[16:1] = d; end
        else w[29] = 1'b1;
        if (($countones(w) % 2) == 0) w[0] = 1'b1;
        return w;
    endfunction

    task automatic wait_ready();
        for (int i = 0; i < 2000 && req_ready !== 1'b1; i++) @(negedge clk);
    endtask

    // issues a request and collects the outputs at the done pulse
    task automatic run_txn(input logic [1:0] k, input logic [7:0] a, input logic [15:0] d,
                           output logic [15:0] res, output logic [1:0] sts,
                           output logic [2:0] we);
        int guard;
        wait_ready();
        @(negedge clk);
        fidx = 0;
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "ready low once busy", {31'd0, req_ready}, 32'd0);
        guard = 0;
        while (done !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
        chk("R10", "done seen", {31'd0, done}, 32'd1);
        chk("R10", "sclk high, cs low at done", {30'd0, spi_sclk, spi_cs_n}, 32'd2);
        res = rd_result; sts = rd_status; we = wr_error;
        @(negedge clk);
        chk("R10", "done one cycle", {31'd0, done}, 32'd0);
        wait_ready();
    endtask

    initial begin
        logic [15:0] res;
        logic [1:0]  sts;
        logic [2:0]  we;
        bit          prev_wr;
        for (int i = 0; i < 4; i++) begin replies[i] = '0; frames[i] = '0; rises[i] = 0; gaps[i] = 0; end

        // reset state
        repeat (3) @(negedge clk);
        chk("R11", "reset cs/sclk/ready/done", {28'd0, spi_cs_n, spi_sclk, req_ready, done}, 32'hA);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "idle after reset", {28'd0, spi_cs_n, spi_sclk, req_ready, done}, 32'hA);

        prev_wr = 1'b0;
        for (int v = 0; v < 8; v++) begin
            logic [1:0]  k    = VEC[v][78:77];
            logic [7:0]  a    = VEC[v][76:69];
            logic [15:0] d    = VEC[v][68:53];
            logic [1:0]  es   = VEC[v][52:51];
            logic [15:0] ev   = VEC[v][50:35];
            logic [2:0]  ee   = VEC[v][34:32];
            logic [31:0] bg   = VEC[v][31:0];
            logic [31:0] rep;
            if (k == 2'd0)
                rep = (bg & ~32'h0FFF_FC00) | {4'd0, es, ev, 10'd0};
            else if (k == 2'd1)
                rep = (bg & ~32'h0C1F_FFE0) | {4'd0, es, 5'd0, ev, 5'd0};
            else
                rep = (bg & ~32'hEC1F_FFE0) | {ee, 1'b0, es, 5'd0, ev, 5'd0};
            if (k == 2'd2) begin replies[0] = rep; replies[1] = 32'hFFFF_FFFF; end
            else begin replies[0] = 32'hFFFF_FFFF; replies[1] = rep; end

            run_txn(k, a, d, res, sts, we);

            chk("R2", $sformatf("vec%0d command word", v), frames[0], exp_cmd(k, a, d));
            chk("R3", $sformatf("vec%0d odd parity", v), $countones(frames[0]) % 2, 32'd1);
            chk("R1", $sformatf("vec%0d rising edges", v), rises[0], 32'd32);
            chk("R6", $sformatf("vec%0d status", v), {30'd0, sts}, {30'd0, es});
            chk("R6", $sformatf("vec%0d write error", v), {29'd0, we},
                (k == 2'd2) ? {29'd0, ee} : 32'd0);
            if (prev_wr)
                chk_ge("R7", $sformatf("vec%0d gap after write", v), gaps[0], WRG);
            if (k == 2'd2) begin
                chk("R7", $sformatf("vec%0d single frame", v), fidx, 32'd1);
                chk("R7", $sformatf("vec%0d write result", v), {16'd0, res}, {16'd0, ev});
            end else begin
                chk(k == 2'd1 ? "R4" : "R5", $sformatf("vec%0d two frames", v), fidx, 32'd2);
                chk(k == 2'd1 ? "R4" : "R5", $sformatf("vec%0d second frame zero", v), frames[1], 32'd0);
                chk(k == 2'd1 ? "R4" : "R5", $sformatf("vec%0d result", v), {16'd0, res}, {16'd0, ev});
                chk("R1", $sformatf("vec%0d second frame edges", v), rises[1], 32'd32);
                chk_ge("R8", $sformatf("vec%0d gap between frames", v), gaps[1], CSG);
            end
            prev_wr = (k == 2'd2);
        end

        // request held valid while a read is in flight is ignored
        begin
            bit busy_ok = 1'b1;
            replies[0] = 32'hFFFF_FFFF;
            replies[1] = {4'h0, 2'd1, 5'd0, 16'h5A5A, 5'd0};
            wait_ready();
            @(negedge clk);
            fidx = 0;
            req_valid = 1'b1; req_kind = 2'd1; req_addr = 8'h04; req_wdata = 16'h0000;
            @(negedge clk);
            req_kind = 2'd2; req_addr = 8'hFF; req_wdata = 16'hFFFF;
            for (int i = 0; i < 100; i++) begin
                if (req_ready !== 1'b0) busy_ok = 1'b0;
                @(negedge clk);
            end
            req_valid = 1'b0;
            chk("R9", "ready stayed low while busy", {31'd0, busy_ok}, 32'd1);
            for (int i = 0; i < 5000 && done !== 1'b1; i++) @(negedge clk);
            chk("R9", "busy read result", {16'd0, rd_result}, 32'h5A5A);
            wait_ready();
            repeat (20) @(negedge clk);
            chk("R9", "no extra frame", fidx, 32'd2);
            chk("R9", "command unchanged", frames[0], exp_cmd(2'd1, 8'h04, 16'h0000));
        end

        // back-to-back write then rate fetch: stretched idle gap
        replies[0] = 32'h0; replies[1] = 32'h0;
        run_txn(2'd2, 8'h20, 16'h0001, res, sts, we);
        run_txn(2'd0, 8'h00, 16'h0000, res, sts, we);
        chk_ge("R7", "write gap before next request", gaps[0], WRG);
        chk_ge("R8", "rate frame gap", gaps[1], CSG);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule